// File: doc/BRIEF.md
# Configuration Phase Sequencer

This block steers a device through its configuration run in three fixed phases: erasing the configuration memory, accepting configuration data, and starting up the device logic. A run begins when the power-on reset is released, and again whenever a qualified pulse arrives on the active-low reprogram input. The block tells the memory array to erase itself, enables the data loader, triggers the startup logic, and raises a completion flag once startup reports that it has finished.

The block shares an open-drain initialisation line with other devices on the board. The block pulls the line Low while the memory is being erased and while a load error is pending. Because any other device can also hold the line Low, the block watches the line's real level. It does not move on to loading until that level reads High through a two-flop synchronizer. A reprogram request counts only if the input stays Low for a minimum number of consecutive clock samples. A valid request restarts the run from any state.

The states are ST_CLEAR (memory erase, line pulled Low), ST_HOLD (line released, waiting for it to read High), ST_LOAD (data loading enabled), ST_STARTUP (startup triggered), ST_DONE (configuration complete) and ST_ERROR (load failure, line pulled Low). The transitions are:
- Power-on reset to ST_CLEAR.
- ST_CLEAR to ST_HOLD when the erase-complete input is high.
- ST_HOLD to ST_LOAD when the synchronised line level is High.
- ST_LOAD to ST_ERROR when the load-error input is high. This takes priority over load completion.
- ST_LOAD to ST_STARTUP when the load-done input is high.
- ST_STARTUP to ST_DONE when the startup-done input is high.
- Any state to ST_CLEAR when the reprogram request is valid.

Top module: `cfg_phase_seq`

## Requirements
- R1: While `rst_n` is Low and on the first cycle after it is released, `clear_req`=1, `init_drive_low`=1, `load_en`=0, `startup_go`=0 and `done`=0.
- R2: While `clear_req` is high, `clear_done`=1 moves the sequencer to the hold state on the next edge: `clear_req` and `init_drive_low` fall to 0 and `load_en` stays 0.
- R3: `load_en` rises only on the third clock edge after `init_in` reads High in the hold state, and only if `init_in` stayed High through those edges. While an external driver keeps `init_in` Low, `load_en` stays 0 for any length of time.
- R4: While `load_en`=1, `load_done`=1 without `load_err` makes `startup_go`=1 and `load_en`=0 on the next cycle.
- R5: `done` rises only on the cycle after `startup_go`=1 and `startup_done`=1, and it then stays high until a reprogram or a reset.
- R6: While `load_en`=1, `load_err`=1 (even together with `load_done`) moves the sequencer to the error state on the next edge: `init_drive_low`=1, `done`=0, `load_en`=0. The state is held regardless of `clear_done`, `load_done` and `startup_done`. Only a valid reprogram or a reset ends it.
- R7: A Low on `prog_n` lasting at least PROG_MIN_LOW (default 30) consecutive clock samples returns the sequencer to the erase state from any state, with `clear_req`=1 and `done`=0. A shorter pulse has no effect.
- R8: While `prog_n` stays Low after qualifying, the sequencer remains in the erase state, and `clear_done` is ignored.
- R9: At most one of `clear_req`, `load_en`, `startup_go` and `done` is high in any cycle.
- R10: `init_drive_low` is high whenever `clear_req` is high.
- R11: Asserting `rst_n` Low from any state returns the sequencer to the erase state without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Power-on reset, active Low, asynchronous |
| prog_n | input | 1 | Reprogram request, active Low, asynchronous |
| init_in | input | 1 | Level read back from the shared open-drain initialisation line |
| init_drive_low | output | 1 | Enables the open-drain pull-down on the initialisation line |
| clear_req | output | 1 | Tells the memory array to erase itself |
| clear_done | input | 1 | Memory erase has finished |
| load_en | output | 1 | Enables the configuration data loader |
| load_done | input | 1 | All configuration data has been accepted |
| load_err | input | 1 | The loader found an error |
| startup_go | output | 1 | Triggers the startup sequence |
| startup_done | input | 1 | The startup sequence has finished |
| done | output | 1 | Configuration complete |

## Verification
The hardest situation to reach is the one where the block has released the initialisation line but the line still reads Low. Erase has finished, yet a second open-drain driver is stretching the phase. The bench models the pad as a wired-AND of the block's pull-down and its own extra pull-down. It holds the extra pull-down on across the erase-complete event and for many cycles after it, then lets go, and checks that loading starts exactly three edges later. The reprogram filter is exercised at its boundary with pulses one sample short of the minimum and exactly at the minimum. A long held pulse confirms that the erase phase cannot be left while the request persists.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    typedef enum logic [2:0] {
        ST_CLEAR   = 3'd0,
        ST_HOLD    = 3'd1,
        ST_LOAD    = 3'd2,
        ST_STARTUP = 3'd3,
        ST_DONE    = 3'd4,
        ST_ERROR   = 3'd5
    } seq_state_t;

    localparam int SYNC_STAGES = 2;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cfg_prog_qual.sv
module cfg_prog_qual #(
    parameter int MIN_LOW = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_s,
    output logic prog_valid
);
    localparam int CW = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MIN_LOW);

    logic [CW-1:0] low_cnt;

    // Counts consecutive Low samples and saturates at the limit.
    // A single High sample clears the count.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (prog_s) begin
            low_cnt <= '0;
        end else if (low_cnt != LIMIT) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign prog_valid = (low_cnt == LIMIT);
endmodule

// File: rtl/cfg_phase_fsm.sv
module cfg_phase_fsm
    import cfg_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic prog_valid,
    input  logic init_s,
    input  logic clear_done,
    input  logic load_done,
    input  logic load_err,
    input  logic startup_done,
    output logic init_drive_low,
    output logic clear_req,
    output logic load_en,
    output logic startup_go,
    output logic done
);
    seq_state_t state, nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_CLEAR;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        if (prog_valid) begin
            nxt = ST_CLEAR;
        end else begin
            unique case (state)
                ST_CLEAR:   if (clear_done)   nxt = ST_HOLD;
                ST_HOLD:    if (init_s)       nxt = ST_LOAD;
                ST_LOAD: begin
                    if (load_err)             nxt = ST_ERROR;
                    else if (load_done)       nxt = ST_STARTUP;
                end
                ST_STARTUP: if (startup_done) nxt = ST_DONE;
                ST_DONE:                      nxt = ST_DONE;
                ST_ERROR:                     nxt = ST_ERROR;
                default:                      nxt = ST_CLEAR;
            endcase
        end
    end

    // Outputs
    always_comb begin
        init_drive_low = 1'b0;
        clear_req      = 1'b0;
        load_en        = 1'b0;
        startup_go     = 1'b0;
        done           = 1'b0;
        unique case (state)
            ST_CLEAR: begin
                init_drive_low = 1'b1;
                clear_req      = 1'b1;
            end
            ST_HOLD:    ;
            ST_LOAD:    load_en    = 1'b1;
            ST_STARTUP: startup_go = 1'b1;
            ST_DONE:    done       = 1'b1;
            ST_ERROR:   init_drive_low = 1'b1;
            default: begin
                init_drive_low = 1'b1;
                clear_req      = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/cfg_phase_seq.sv
module cfg_phase_seq #(
    parameter int PROG_MIN_LOW = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_n,
    input  logic init_in,
    output logic init_drive_low,
    output logic clear_req,
    input  logic clear_done,
    output logic load_en,
    input  logic load_done,
    input  logic load_err,
    output logic startup_go,
    input  logic startup_done,
    output logic done
);
    import cfg_seq_pkg::*;

    logic init_s;
    logic prog_s;
    logic prog_valid;

    cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_init_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (init_in),
        .q     (init_s)
    );

    cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_prog_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (prog_n),
        .q     (prog_s)
    );

    cfg_prog_qual #(.MIN_LOW(PROG_MIN_LOW)) u_prog_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_s     (prog_s),
        .prog_valid (prog_valid)
    );

    cfg_phase_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .prog_valid     (prog_valid),
        .init_s         (init_s),
        .clear_done     (clear_done),
        .load_done      (load_done),
        .load_err       (load_err),
        .startup_done   (startup_done),
        .init_drive_low (init_drive_low),
        .clear_req      (clear_req),
        .load_en        (load_en),
        .startup_go     (startup_go),
        .done           (done)
    );
endmodule

// File: rtl/cfg_phase_seq_chk.sv
module cfg_phase_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic init_in,
    input logic init_drive_low,
    input logic clear_req,
    input logic clear_done,
    input logic load_en,
    input logic load_done,
    input logic load_err,
    input logic startup_go,
    input logic startup_done,
    input logic done,
    input logic prog_valid
);
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |-> (clear_req && init_drive_low && !load_en && !done));

    a_r2_clear_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_req && clear_done && !prog_valid) |=> (!clear_req && !init_drive_low && !load_en));

    a_r3_load_after_init: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_en) |-> ($past(init_in, 1) && $past(init_in, 2)));

    a_r4_startup_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && load_done && !load_err && !prog_valid) |=> (startup_go && !load_en));

    a_r5_done_after_startup: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(startup_go) && $past(startup_done)));

    a_r6_error_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && load_err && !prog_valid) |=> (init_drive_low && !clear_req && !done && !load_en));

    a_r6_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (init_drive_low && !clear_req && !prog_valid) |=> (init_drive_low && !clear_req));

    a_r7_prog_restart: assert property (@(posedge clk) disable iff (!rst_n)
        prog_valid |=> (clear_req && !done));

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clear_req, load_en, startup_go, done}));

    a_r10_drive_in_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear_req |-> init_drive_low);
endmodule

bind cfg_phase_seq cfg_phase_seq_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .init_in        (init_in),
    .init_drive_low (init_drive_low),
    .clear_req      (clear_req),
    .clear_done     (clear_done),
    .load_en        (load_en),
    .load_done      (load_done),
    .load_err       (load_err),
    .startup_go     (startup_go),
    .startup_done   (startup_done),
    .done           (done),
    .prog_valid     (prog_valid)
);

// File: tb/cfg_phase_seq_tb.sv
module cfg_phase_seq_tb;
    localparam int MIN_LOW = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prog_n = 1'b1;
    logic ext_hold = 1'b0;
    logic init_in;
    logic init_drive_low, clear_req, load_en, startup_go, done;
    logic clear_done = 1'b0, load_done = 1'b0, load_err = 1'b0, startup_done = 1'b0;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    // Wired-AND model of the open-drain pad
    assign init_in = !(init_drive_low || ext_hold);

    cfg_phase_seq #(.PROG_MIN_LOW(MIN_LOW)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .prog_n         (prog_n),
        .init_in        (init_in),
        .init_drive_low (init_drive_low),
        .clear_req      (clear_req),
        .clear_done     (clear_done),
        .load_en        (load_en),
        .load_done      (load_done),
        .load_err       (load_err),
        .startup_go     (startup_go),
        .startup_done   (startup_done),
        .done           (done)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        prog_n = 1'b1; ext_hold = 1'b0;
        clear_done = 1'b0; load_done = 1'b0; load_err = 1'b0; startup_done = 1'b0;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
    endtask

    task automatic pulse_clear_done();
        clear_done = 1'b1; wait_n(1); clear_done = 1'b0;
    endtask

    // Runs the sequencer from the erase state to ST_DONE, checking each step.
    task automatic run_to_done();
        pulse_clear_done();
        chk("R2", "clear_req after erase", clear_req, 1'b0);
        chk("R2", "init_drive_low after erase", init_drive_low, 1'b0);
        wait_n(2);
        chk("R3", "load_en before 3rd edge", load_en, 1'b0);
        wait_n(1);
        chk("R3", "load_en on 3rd edge", load_en, 1'b1);
        load_done = 1'b1; wait_n(1); load_done = 1'b0;
        chk("R4", "startup_go", startup_go, 1'b1);
        chk("R4", "load_en off", load_en, 1'b0);
        chk("R9", "done low in startup", done, 1'b0);
        wait_n(3);
        chk("R5", "done waits for startup_done", done, 1'b0);
        startup_done = 1'b1; wait_n(1); startup_done = 1'b0;
        chk("R5", "done high", done, 1'b1);
        chk("R9", "startup_go low when done", startup_go, 1'b0);
        wait_n(5);
        chk("R5", "done stays high", done, 1'b1);
    endtask

    task automatic prog_pulse(input int len);
        prog_n = 1'b0; wait_n(len); prog_n = 1'b1;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        rst_n = 1'b0;
        wait_n(1);
        chk("R1", "clear_req in reset", clear_req, 1'b1);
        chk("R1", "init_drive_low in reset", init_drive_low, 1'b1);
        chk("R1", "done in reset", done, 1'b0);
        rst_n = 1'b1;
        wait_n(1);
        chk("R1", "clear_req after reset", clear_req, 1'b1);
        chk("R1", "load_en after reset", load_en, 1'b0);
        chk("R1", "startup_go after reset", startup_go, 1'b0);
    endtask

    task automatic t_normal_flow();
        do_reset();
        wait_n(4);
        chk("R2", "stays in erase without clear_done", clear_req, 1'b1);
        run_to_done();
    endtask

    task automatic t_ext_hold();
        do_reset();
        ext_hold = 1'b1;
        pulse_clear_done();
        chk("R2", "released after erase", init_drive_low, 1'b0);
        wait_n(60);
        chk("R3", "load_en held off by external Low", load_en, 1'b0);
        chk("R3", "line still Low", init_in, 1'b0);
        ext_hold = 1'b0;
        wait_n(2);
        chk("R3", "load_en not yet after release", load_en, 1'b0);
        wait_n(1);
        chk("R3", "load_en after external release", load_en, 1'b1);
    endtask

    task automatic t_prog_boundary();
        do_reset();
        run_to_done();
        prog_pulse(MIN_LOW - 1);
        wait_n(8);
        chk("R7", "short pulse ignored, done", done, 1'b1);
        chk("R7", "short pulse ignored, clear_req", clear_req, 1'b0);
        prog_pulse(MIN_LOW);
        wait_n(8);
        chk("R7", "valid pulse drops done", done, 1'b0);
        chk("R7", "valid pulse restarts erase", clear_req, 1'b1);
        chk("R10", "line driven in erase", init_drive_low, 1'b1);
        run_to_done();
    endtask

    task automatic t_prog_held();
        do_reset();
        run_to_done();
        prog_n = 1'b0;
        wait_n(MIN_LOW + 10);
        chk("R8", "erase while held", clear_req, 1'b1);
        pulse_clear_done();
        wait_n(2);
        chk("R8", "clear_done ignored while held", clear_req, 1'b1);
        chk("R8", "line still driven", init_drive_low, 1'b1);
        prog_n = 1'b1;
        wait_n(5);
        chk("R8", "erase after release", clear_req, 1'b1);
        run_to_done();
    endtask

    task automatic t_load_error(input bit with_done);
        do_reset();
        pulse_clear_done();
        wait_n(3);
        chk("R3", "load_en before error", load_en, 1'b1);
        load_err = 1'b1; load_done = with_done;
        wait_n(1);
        load_err = 1'b0; load_done = 1'b0;
        chk("R6", "error drives line", init_drive_low, 1'b1);
        chk("R6", "error load_en off", load_en, 1'b0);
        chk("R6", "error no startup", startup_go, 1'b0);
        pulse_clear_done();
        startup_done = 1'b1; load_done = 1'b1;
        wait_n(3);
        startup_done = 1'b0; load_done = 1'b0;
        chk("R6", "error sticky, line", init_drive_low, 1'b1);
        chk("R6", "error sticky, clear_req", clear_req, 1'b0);
        chk("R6", "error sticky, done", done, 1'b0);
        prog_pulse(MIN_LOW);
        wait_n(6);
        chk("R6", "reprogram leaves error", clear_req, 1'b1);
        run_to_done();
    endtask

    task automatic t_async_reset();
        do_reset();
        pulse_clear_done();
        wait_n(3);
        chk("R11", "in load before reset", load_en, 1'b1);
        #1 rst_n = 1'b0;
        #0.5;
        chk("R11", "clear_req without edge", clear_req, 1'b1);
        chk("R11", "load_en off without edge", load_en, 1'b0);
        wait_n(1);
        rst_n = 1'b1;
        wait_n(1);
    endtask

    initial begin
        wait_n(2);
        t_reset_state();
        t_normal_flow();
        t_ext_hold();
        t_prog_boundary();
        t_prog_held();
        t_load_error(1'b0);
        t_load_error(1'b1);
        t_async_reset();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule